// File: doc/BRIEF.md
# Receive FIFO Drain Threshold Controller

This block sits beside a receive FIFO that the network receive path fills. It decides when the receive bus-master engine may start copying FIFO contents to host memory. A drain request is raised in two cases: the FIFO holds as many bytes as a programmable threshold, or at least one whole packet has landed in the FIFO. The threshold is a 6-bit field counted in 8-byte steps, so the byte level is the field value times 8, from 8 to 504 bytes.

The same threshold is compared with the running byte count of the packet now arriving. When that count first reaches the threshold, the block raises a one-cycle early-receive interrupt request. It raises it only once per packet and re-arms at the next packet start. A threshold field of zero is not a valid setting. It sets a sticky configuration-error flag and disables both threshold comparisons. The complete-packet trigger keeps working.

A low threshold can let draining begin before the filter has decided whether to keep the packet. If the filter then rejects that packet, the block emits a quiet-drop pulse. This tells the writeback logic to report neither success nor error for the packet.

The block holds four state machines:
- Drain FSM: `DR_IDLE` goes to `DR_REQ` on a trigger, and `DR_REQ` goes back to `DR_IDLE` on acknowledge.
- Early-interrupt FSM: `EI_ARMED` goes to `EI_FIRE` when the length is reached. `EI_FIRE` goes to `EI_SPENT`. `EI_SPENT` goes to `EI_ARMED` on packet start, and `EI_FIRE` does the same when a packet starts in that cycle.
- Configuration FSM: `CF_OK` goes to `CF_BAD` on a zero field. `CF_BAD` is left only by reset.
- Verdict FSM: a packet start from any state enters `PK_RECV`. `PK_RECV` goes to `PK_EXPOSED` on a drain acknowledge, and to `PK_IDLE` on a reject or on packet end. `PK_EXPOSED` goes to `PK_QUIET` on a reject. `PK_QUIET` goes to `PK_IDLE`.

Top module: `rx_drain_ctrl`

## Requirements
- R1: With a nonzero threshold field T, `drain_req` is high in the cycle after `fifo_bytes` is sampled at or above T*8 (the field value shifted left by 3).
- R2: `drain_req` is high in the cycle after `eop_present` is sampled high, whatever the byte count.
- R3: Once high, `drain_req` stays high until `drain_ack` is sampled high. It is then low for the next cycle, and the triggers are evaluated again in that cycle.
- R4: A zero threshold field sets `cfg_err` in the next cycle. `cfg_err` stays set until reset. While the field is zero, neither the byte count nor the packet length raises `drain_req` or `early_irq`.
- R5: With a zero threshold field, a complete packet (`eop_present`) still raises `drain_req`.
- R6: `early_irq` is a single-cycle pulse. It appears in the cycle after `pkt_len` is sampled at or above T*8, and at most once per packet.
- R7: A `pkt_start` pulse re-arms the early interrupt, so the next packet that reaches the threshold fires it again.
- R8: `quiet_drop` pulses for one cycle after a `filt_reject` that follows a `drain_ack` taken between `pkt_start` and `pkt_end`. A reject with no such prior acknowledge gives no pulse.
- R9: After reset, `drain_req`, `early_irq`, `quiet_drop` and `cfg_err` are all low.
- R10: A byte count of T*8-1 with no complete packet leaves `drain_req` low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| thr_units | input | 6 | Drain threshold in 8-byte units |
| fifo_bytes | input | 12 | Bytes currently in the receive FIFO |
| eop_present | input | 1 | FIFO holds at least one complete packet |
| pkt_start | input | 1 | Pulse: a new packet begins arriving |
| pkt_end | input | 1 | Pulse: the arriving packet has ended |
| pkt_len | input | 16 | Accumulated byte count of the arriving packet |
| filt_reject | input | 1 | Pulse: the filter rejected the arriving packet |
| drain_ack | input | 1 | Bus-master engine accepts the drain request |
| drain_req | output | 1 | Request to start moving FIFO data to host |
| early_irq | output | 1 | One-cycle early-receive interrupt request |
| quiet_drop | output | 1 | Pulse: rejected packet already draining, suppress status |
| cfg_err | output | 1 | Sticky flag: zero threshold was programmed |

## Verification
On every cycle, the bound assertions check the following:
- the request hand-off: the request holds without an acknowledge and drops after one;
- both drain triggers, and that nothing fires below the threshold;
- that a zero field blocks both threshold uses and latches the error;
- that the interrupt and quiet-drop outputs are single-cycle pulses.

Other behaviours need multi-cycle packet stories, so only the bench scenarios can show them:
- the once-per-packet limit on the interrupt and its re-arming;
- which orders of acknowledge, packet end and reject produce a quiet drop;
- that the error survives a later valid threshold until reset.

// File: rtl/rxd_pkg.sv
package rxd_pkg;

    typedef enum logic {
        DR_IDLE,
        DR_REQ
    } drain_st_e;

    typedef enum logic [1:0] {
        EI_ARMED,
        EI_FIRE,
        EI_SPENT
    } early_st_e;

    typedef enum logic {
        CF_OK,
        CF_BAD
    } cfg_st_e;

    typedef enum logic [1:0] {
        PK_IDLE,
        PK_RECV,
        PK_EXPOSED,
        PK_QUIET
    } pkt_st_e;

endpackage

// File: rtl/rxd_thresh.sv
// Scales the threshold field to bytes, compares it with the FIFO level and
// the running packet length, and tracks the zero-field configuration error.
module rxd_thresh
    import rxd_pkg::*;
#(
    parameter int THR_W  = 6,
    parameter int CNT_W  = 12,
    parameter int LEN_W  = 16,
    parameter int UNIT_SH = 3
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [THR_W-1:0] thr_units,
    input  logic [CNT_W-1:0] fifo_bytes,
    input  logic [LEN_W-1:0] pkt_len,
    output logic             thr_valid,
    output logic             fifo_hit,
    output logic             len_hit,
    output logic             cfg_err
);
    localparam int EFF_W = THR_W + UNIT_SH;
    localparam int CMP_W = EFF_W + CNT_W + LEN_W;

    logic [EFF_W-1:0] eff_bytes;
    logic [CMP_W-1:0] eff_ext;
    logic [CMP_W-1:0] fifo_ext;
    logic [CMP_W-1:0] len_ext;

    cfg_st_e cfg_q, cfg_d;

    always_comb begin
        eff_bytes = {thr_units, {UNIT_SH{1'b0}}};
        eff_ext   = CMP_W'(eff_bytes);
        fifo_ext  = CMP_W'(fifo_bytes);
        len_ext   = CMP_W'(pkt_len);
        thr_valid = (thr_units != '0);
        fifo_hit  = thr_valid && (fifo_ext >= eff_ext);
        len_hit   = thr_valid && (len_ext >= eff_ext);
    end

    // state register
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cfg_q <= CF_OK;
        end else begin
            cfg_q <= cfg_d;
        end
    end

    // next state
    always_comb begin
        cfg_d = cfg_q;
        unique case (cfg_q)
            CF_OK:   if (!thr_valid) cfg_d = CF_BAD;
            CF_BAD:  cfg_d = CF_BAD;
            default: cfg_d = CF_OK;
        endcase
    end

    // outputs
    always_comb begin
        cfg_err = (cfg_q == CF_BAD);
    end

endmodule

// File: rtl/rxd_drain_fsm.sv
// Raises the drain request on either trigger and holds it until acknowledged.
module rxd_drain_fsm
    import rxd_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic fifo_hit,
    input  logic eop_present,
    input  logic drain_ack,
    output logic drain_req
);
    drain_st_e st_q, st_d;
    logic      trigger;

    always_comb begin
        trigger = fifo_hit || eop_present;
    end

    // state register
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q <= DR_IDLE;
        end else begin
            st_q <= st_d;
        end
    end

    // next state
    always_comb begin
        st_d = st_q;
        unique case (st_q)
            DR_IDLE: if (trigger)   st_d = DR_REQ;
            DR_REQ:  if (drain_ack) st_d = DR_IDLE;
            default: st_d = DR_IDLE;
        endcase
    end

    // outputs
    always_comb begin
        drain_req = (st_q == DR_REQ);
    end

endmodule

// File: rtl/rxd_early_fsm.sv
// One early-receive pulse per packet, re-armed by each packet start.
module rxd_early_fsm
    import rxd_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic pkt_start,
    input  logic len_hit,
    output logic early_irq
);
    early_st_e st_q, st_d;

    // state register
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q <= EI_ARMED;
        end else begin
            st_q <= st_d;
        end
    end

    // next state: a packet start always wins and re-arms
    always_comb begin
        st_d = st_q;
        unique case (st_q)
            EI_ARMED: begin
                if (!pkt_start && len_hit) st_d = EI_FIRE;
            end
            EI_FIRE: begin
                st_d = pkt_start ? EI_ARMED : EI_SPENT;
            end
            EI_SPENT: begin
                if (pkt_start) st_d = EI_ARMED;
            end
            default: st_d = EI_ARMED;
        endcase
    end

    // outputs
    always_comb begin
        early_irq = (st_q == EI_FIRE);
    end

endmodule

// File: rtl/rxd_verdict_fsm.sv
// Notices a filter reject that arrives after draining of the same,
// still incomplete, packet was accepted, and flags it for silent discard.
module rxd_verdict_fsm
    import rxd_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic pkt_start,
    input  logic pkt_end,
    input  logic drain_ack,
    input  logic filt_reject,
    output logic quiet_drop
);
    pkt_st_e st_q, st_d;

    // state register
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q <= PK_IDLE;
        end else begin
            st_q <= st_d;
        end
    end

    // next state: start > reject > acknowledge > end
    always_comb begin
        st_d = st_q;
        if (pkt_start) begin
            st_d = PK_RECV;
        end else begin
            unique case (st_q)
                PK_IDLE: st_d = PK_IDLE;
                PK_RECV: begin
                    if (filt_reject)    st_d = PK_IDLE;
                    else if (drain_ack) st_d = PK_EXPOSED;
                    else if (pkt_end)   st_d = PK_IDLE;
                end
                PK_EXPOSED: begin
                    if (filt_reject) st_d = PK_QUIET;
                end
                PK_QUIET: st_d = PK_IDLE;
                default:  st_d = PK_IDLE;
            endcase
        end
    end

    // outputs
    always_comb begin
        quiet_drop = (st_q == PK_QUIET);
    end

endmodule

// File: rtl/rx_drain_ctrl.sv
// Receive FIFO drain threshold controller: top level.
module rx_drain_ctrl #(
    parameter int THR_W   = 6,
    parameter int CNT_W   = 12,
    parameter int LEN_W   = 16,
    parameter int UNIT_SH = 3
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [THR_W-1:0] thr_units,
    input  logic [CNT_W-1:0] fifo_bytes,
    input  logic             eop_present,
    input  logic             pkt_start,
    input  logic             pkt_end,
    input  logic [LEN_W-1:0] pkt_len,
    input  logic             filt_reject,
    input  logic             drain_ack,
    output logic             drain_req,
    output logic             early_irq,
    output logic             quiet_drop,
    output logic             cfg_err
);
    logic thr_valid;
    logic fifo_hit;
    logic len_hit;

    rxd_thresh #(
        .THR_W  (THR_W),
        .CNT_W  (CNT_W),
        .LEN_W  (LEN_W),
        .UNIT_SH(UNIT_SH)
    ) u_thresh (
        .clk       (clk),
        .rst_n     (rst_n),
        .thr_units (thr_units),
        .fifo_bytes(fifo_bytes),
        .pkt_len   (pkt_len),
        .thr_valid (thr_valid),
        .fifo_hit  (fifo_hit),
        .len_hit   (len_hit),
        .cfg_err   (cfg_err)
    );

    rxd_drain_fsm u_drain (
        .clk        (clk),
        .rst_n      (rst_n),
        .fifo_hit   (fifo_hit),
        .eop_present(eop_present),
        .drain_ack  (drain_ack),
        .drain_req  (drain_req)
    );

    rxd_early_fsm u_early (
        .clk      (clk),
        .rst_n    (rst_n),
        .pkt_start(pkt_start),
        .len_hit  (len_hit),
        .early_irq(early_irq)
    );

    rxd_verdict_fsm u_verdict (
        .clk        (clk),
        .rst_n      (rst_n),
        .pkt_start  (pkt_start),
        .pkt_end    (pkt_end),
        .drain_ack  (drain_ack),
        .filt_reject(filt_reject),
        .quiet_drop (quiet_drop)
    );

endmodule

// File: rtl/rx_drain_ctrl_checker.sv
module rx_drain_ctrl_checker #(
    parameter int THR_W   = 6,
    parameter int CNT_W   = 12,
    parameter int LEN_W   = 16,
    parameter int UNIT_SH = 3
) (
    input logic             clk,
    input logic             rst_n,
    input logic [THR_W-1:0] thr_units,
    input logic [CNT_W-1:0] fifo_bytes,
    input logic             eop_present,
    input logic             pkt_start,
    input logic             drain_ack,
    input logic             drain_req,
    input logic             early_irq,
    input logic             quiet_drop,
    input logic             cfg_err
);
    logic at_level;
    logic below_level;

    always_comb begin
        at_level    = (thr_units != '0) &&
                      (int'(fifo_bytes) >= (int'(thr_units) << UNIT_SH));
        below_level = (thr_units == '0) ||
                      (int'(fifo_bytes) < (int'(thr_units) << UNIT_SH));
    end

    AST_LEVEL_TRIG: assert property (@(posedge clk) disable iff (!rst_n)
        (!drain_req && at_level) |=> drain_req); // R1

    AST_EOP_TRIG: assert property (@(posedge clk) disable iff (!rst_n)
        (!drain_req && eop_present) |=> drain_req); // R2

    AST_REQ_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (drain_req && !drain_ack) |=> drain_req); // R3

    AST_REQ_RELEASE: assert property (@(posedge clk) disable iff (!rst_n)
        (drain_req && drain_ack) |=> !drain_req); // R3

    AST_ZERO_FLAG: assert property (@(posedge clk) disable iff (!rst_n)
        (thr_units == '0) |=> cfg_err); // R4

    AST_ERR_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
        cfg_err |=> cfg_err); // R4

    AST_ZERO_NO_IRQ: assert property (@(posedge clk) disable iff (!rst_n)
        (thr_units == '0) |=> !early_irq); // R4

    AST_IRQ_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
        early_irq |=> !early_irq); // R6

    AST_QUIET_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
        quiet_drop |=> !quiet_drop); // R8

    AST_BELOW_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
        (!drain_req && !eop_present && below_level) |=> !drain_req); // R10

    AST_START_NO_IRQ: assert property (@(posedge clk) disable iff (!rst_n)
        (pkt_start && !early_irq) |=> !early_irq); // R7

endmodule

bind rx_drain_ctrl rx_drain_ctrl_checker #(
    .THR_W  (THR_W),
    .CNT_W  (CNT_W),
    .LEN_W  (LEN_W),
    .UNIT_SH(UNIT_SH)
) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .thr_units  (thr_units),
    .fifo_bytes (fifo_bytes),
    .eop_present(eop_present),
    .pkt_start  (pkt_start),
    .drain_ack  (drain_ack),
    .drain_req  (drain_req),
    .early_irq  (early_irq),
    .quiet_drop (quiet_drop),
    .cfg_err    (cfg_err)
);

// File: tb/rx_drain_ctrl_tb.sv
`timescale 1ns/1ps
module rx_drain_ctrl_tb;

    logic        clk = 1'b0;
    logic        rst_n;
    logic [5:0]  thr_units;
    logic [11:0] fifo_bytes;
    logic        eop_present;
    logic        pkt_start;
    logic        pkt_end;
    logic [15:0] pkt_len;
    logic        filt_reject;
    logic        drain_ack;
    logic        drain_req;
    logic        early_irq;
    logic        quiet_drop;
    logic        cfg_err;

    int total = 0;
    int bad   = 0;

    always #2 clk = ~clk;

    rx_drain_ctrl u_dut (
        .clk        (clk),
        .rst_n      (rst_n),
        .thr_units  (thr_units),
        .fifo_bytes (fifo_bytes),
        .eop_present(eop_present),
        .pkt_start  (pkt_start),
        .pkt_end    (pkt_end),
        .pkt_len    (pkt_len),
        .filt_reject(filt_reject),
        .drain_ack  (drain_ack),
        .drain_req  (drain_req),
        .early_irq  (early_irq),
        .quiet_drop (quiet_drop),
        .cfg_err    (cfg_err)
    );

    // {thr[5:0], fifo[11:0], eop, expected drain_req}
    localparam int NV = 10;
    localparam logic [19:0] VEC [NV] = '{
        {6'd1,  12'd7,    1'b0, 1'b0},  // R10 one below 8
        {6'd1,  12'd8,    1'b0, 1'b1},  // R1
        {6'd4,  12'd31,   1'b0, 1'b0},  // R10
        {6'd4,  12'd32,   1'b0, 1'b1},  // R1
        {6'd63, 12'd503,  1'b0, 1'b0},  // R10 top of range
        {6'd63, 12'd504,  1'b0, 1'b1},  // R1
        {6'd63, 12'd0,    1'b1, 1'b1},  // R2 empty count, whole packet
        {6'd10, 12'd79,   1'b1, 1'b1},  // R2
        {6'd2,  12'd4095, 1'b0, 1'b1},  // R1 full counter
        {6'd63, 12'd100,  1'b0, 1'b0}   // R10
    };

    task automatic step();
        @(negedge clk);
    endtask

    task automatic chk(input string tag, input logic act, input logic exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s: actual=%b expected=%b at %0t", tag, act, exp, $time);
        end
    endtask

    task automatic do_reset();
        rst_n       = 1'b0;
        thr_units   = 6'd1;
        fifo_bytes  = '0;
        eop_present = 1'b0;
        pkt_start   = 1'b0;
        pkt_end     = 1'b0;
        pkt_len     = '0;
        filt_reject = 1'b0;
        drain_ack   = 1'b0;
        step();
        step();
        rst_n = 1'b1;
        step();
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        bad++;
        $display("FAIL watchdog: actual=timeout expected=finish");
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        @(negedge clk);
        do_reset();
        chk("R9 drain_req", drain_req, 1'b0);
        chk("R9 early_irq", early_irq, 1'b0);
        chk("R9 quiet_drop", quiet_drop, 1'b0);
        chk("R9 cfg_err", cfg_err, 1'b0);

        // vector table: R1, R2, R10
        for (int i = 0; i < NV; i++) begin
            thr_units   = VEC[i][19:14];
            fifo_bytes  = VEC[i][13:2];
            eop_present = VEC[i][1];
            step();
            chk($sformatf("R1/R2/R10 vec%0d", i), drain_req, VEC[i][0]);
            drain_ack   = 1'b1;
            fifo_bytes  = '0;
            eop_present = 1'b0;
            step();
            drain_ack = 1'b0;
            chk($sformatf("R3 vec%0d cleared", i), drain_req, 1'b0);
        end

        // R3: hold without acknowledge, drop one cycle, re-evaluate
        thr_units  = 6'd2;
        fifo_bytes = 12'd16;
        step();
        chk("R1 level 16", drain_req, 1'b1);
        for (int k = 0; k < 3; k++) begin
            step();
            chk("R3 held", drain_req, 1'b1);
        end
        drain_ack = 1'b1;
        step();
        chk("R3 released", drain_req, 1'b0);
        drain_ack = 1'b0;
        step();
        chk("R3 re-raised", drain_req, 1'b1);
        drain_ack  = 1'b1;
        fifo_bytes = '0;
        step();
        drain_ack = 1'b0;

        // R6 / R7: early interrupt, threshold 32 bytes
        thr_units = 6'd4;
        pkt_start = 1'b1;
        pkt_len   = '0;
        step();
        pkt_start = 1'b0;
        pkt_len   = 16'd31;
        step();
        chk("R6 below", early_irq, 1'b0);
        pkt_len = 16'd32;
        step();
        chk("R6 fire", early_irq, 1'b1);
        pkt_len = 16'd40;
        step();
        chk("R6 single cycle", early_irq, 1'b0);
        pkt_len = 16'd100;
        step();
        chk("R6 once per packet", early_irq, 1'b0);
        pkt_start = 1'b1;
        pkt_len   = '0;
        step();
        chk("R7 start quiet", early_irq, 1'b0);
        pkt_start = 1'b0;
        pkt_len   = 16'd32;
        step();
        chk("R7 re-armed", early_irq, 1'b1);
        pkt_len = '0;
        step();

        // R8: reject after an acknowledge taken mid-packet
        pkt_start = 1'b1;
        step();
        pkt_start = 1'b0;
        drain_ack = 1'b1;
        step();
        drain_ack   = 1'b0;
        filt_reject = 1'b1;
        step();
        filt_reject = 1'b0;
        chk("R8 quiet drop", quiet_drop, 1'b1);
        step();
        chk("R8 pulse ends", quiet_drop, 1'b0);

        // R8: reject with no prior acknowledge
        pkt_start = 1'b1;
        step();
        pkt_start   = 1'b0;
        filt_reject = 1'b1;
        step();
        filt_reject = 1'b0;
        chk("R8 plain reject", quiet_drop, 1'b0);
        step();
        chk("R8 plain reject later", quiet_drop, 1'b0);

        // R8: acknowledge only after packet end
        pkt_start = 1'b1;
        step();
        pkt_start = 1'b0;
        pkt_end   = 1'b1;
        step();
        pkt_end   = 1'b0;
        drain_ack = 1'b1;
        step();
        drain_ack   = 1'b0;
        filt_reject = 1'b1;
        step();
        filt_reject = 1'b0;
        chk("R8 ack after end", quiet_drop, 1'b0);

        // R4 / R5: zero threshold
        thr_units  = 6'd0;
        fifo_bytes = 12'd4095;
        step();
        chk("R4 cfg_err set", cfg_err, 1'b1);
        chk("R4 no level trigger", drain_req, 1'b0);
        pkt_start = 1'b1;
        step();
        pkt_start = 1'b0;
        pkt_len   = 16'hFFFF;
        step();
        step();
        chk("R4 no early irq", early_irq, 1'b0);
        chk("R4 still no drain", drain_req, 1'b0);
        eop_present = 1'b1;
        step();
        chk("R5 packet trigger", drain_req, 1'b1);
        eop_present = 1'b0;
        fifo_bytes  = '0;
        pkt_len     = '0;
        thr_units   = 6'd5;
        drain_ack   = 1'b1;
        step();
        drain_ack = 1'b0;
        step();
        chk("R4 sticky", cfg_err, 1'b1);
        do_reset();
        chk("R9 cfg_err cleared", cfg_err, 1'b0);

        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule